// File: doc/BRIEF.md
# Statistical Operation Sampling Selector

This block chooses which operation, out of a stream of candidate operations, is picked for profiling. A pulse on `candValid` marks one candidate in that cycle. The block counts these pulses and selects one candidate each time the count reaches a programmed interval. It can add a pseudo-random offset to the interval so that the sampling points do not lock onto the period of a program loop.

Only one selected operation may be in flight at a time. The block emits a start pulse and the tag of the selected operation, then holds a busy flag until the consumer signals completion. A selection that falls due while an earlier one is still in flight is dropped and counted as a collision. Collisions are counted before any later record filtering. Capturing the operation's data, filtering records and writing them to memory happen outside this block.

Top module: `op_sample_sel`

## Requirements
- R1: With `interval` nonzero and jitter off, the selected candidate is the `interval`-th cycle with `candValid` high since the previous selection point (or since reset). Cycles with `candValid` low are not counted.
- R2: An `interval` of zero selects the fixed minimum interval `MIN_INTERVAL` (default 16) in place of the programmed value.
- R3: The jitter source is a 16-bit LFSR seeded to 16'hACE1. Each step shifts it left by one, with bit 0 taking bit15 xor bit13 xor bit12 xor bit10. It steps once per selection point. At each selection point, if `jitterEn` is high, the 8 low bits of the LFSR (taken before the step) become the offset added to the interval for the next window; otherwise the offset is zero. The first window after reset has offset zero.
- R4: `sampleStart` pulses for one cycle, one clock after the selected candidate, with `sampleTag` equal to that candidate's `candTag`. `busy` rises in the same cycle.
- R5: While `busy` is high, a selection point produces no `sampleStart` and adds one to `collCount`.
- R6: The candidate count restarts at every selection point, whether or not that point collided.
- R7: `doneValid` while `busy` is high clears `busy` at the next edge. A selection point in that same cycle is still a collision. A selection one cycle later may start.
- R8: `collCount` saturates at its all-ones value.
- R9: `collClr` sets `collCount` to zero at the next edge, taking priority over an increment in the same cycle.
- R10: `doneValid` while `busy` is low has no effect on `busy` or on later selections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| candValid | input | 1 | One candidate operation this cycle |
| candTag | input | TAG_W | Identifier of this cycle's candidate |
| interval | input | CNT_W | Candidates per selection; zero selects MIN_INTERVAL |
| jitterEn | input | 1 | Add the LFSR offset to each new window |
| doneValid | input | 1 | In-flight sampled operation has finished |
| collClr | input | 1 | Synchronous clear of the collision count |
| sampleStart | output | 1 | One-cycle pulse: a sample begins |
| sampleTag | output | TAG_W | Tag of the sampled operation |
| busy | output | 1 | A sampled operation is in flight |
| collCount | output | COLL_W | Saturating count of dropped selections |

## Verification
On every cycle the assertions check the single-flight rule, that a start always pairs with a raised busy flag, that completion releases busy, and that the collision count increments, saturates and clears correctly. The exact cycle of each selection can only be shown by the bench's scenarios. This covers how candidate gaps are counted, the zero-interval fallback, the jitter offsets that follow the LFSR sequence, and the reload after a collision. The bench compares these against a reference model that steps cycle by cycle. It uses a narrow collision counter so that saturation can be reached.

// File: rtl/opsamp_pkg.sv
package opsamp_pkg;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic advance;   // a selection point occurred
    logic launch;    // selection accepted, sample starts
    logic collide;   // selection dropped, slot occupied
  } samp_strobe_t;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

  function automatic logic [15:0] lfsr16Next(input logic [15:0] cur);
    return {cur[14:0], cur[15] ^ cur[13] ^ cur[12] ^ cur[10]};
  endfunction

endpackage

// File: rtl/opsamp_ctrl.sv
module opsamp_ctrl
  import opsamp_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         expireHit,
  input  logic         doneValid,
  output samp_strobe_t strb,
  output logic         busy
);

  logic busyQ;

  always_comb begin
    strb.advance = expireHit;
    strb.launch  = expireHit && !busyQ;
    strb.collide = expireHit && busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busyQ <= 1'b0;
    else if (strb.launch) busyQ <= 1'b1;
    else if (doneValid)   busyQ <= 1'b0;
  end

  assign busy = busyQ;

  // R7: completion frees the slot at the next edge
  a_r7_release: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && doneValid |=> !busyQ);

  // R5: without completion the slot stays occupied
  a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    busyQ && !doneValid |=> busyQ);

endmodule

// File: rtl/opsamp_dp.sv
module opsamp_dp
  import opsamp_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int TAG_W        = 8,
  parameter int COLL_W       = 32,
  parameter int JIT_W        = 8,
  parameter int MIN_INTERVAL = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [TAG_W-1:0]  candTag,
  input  logic [CNT_W-1:0]  interval,
  input  logic              jitterEn,
  input  logic              collClr,
  input  samp_strobe_t      strb,
  output logic              expireHit,
  output logic              sampleStart,
  output logic [TAG_W-1:0]  sampleTag,
  output logic [COLL_W-1:0] collCount
);

  localparam int TGT_W = CNT_W + 1;
  localparam logic [COLL_W-1:0] COLL_MAX = '1;
  localparam logic [CNT_W-1:0]  MIN_IVL  = CNT_W'(MIN_INTERVAL);

  logic [TGT_W-1:0]  cntQ;
  logic [JIT_W-1:0]  jitQ;
  logic [15:0]       lfsrQ;
  logic [CNT_W-1:0]  baseIvl;
  logic [TGT_W-1:0]  target;
  logic [TGT_W-1:0]  cntInc;
  logic              startQ;
  logic [TAG_W-1:0]  tagQ;
  logic [COLL_W-1:0] collQ;

  always_comb begin
    baseIvl   = (interval == '0) ? MIN_IVL : interval;
    target    = TGT_W'(baseIvl) + TGT_W'(jitQ);
    cntInc    = cntQ + 1'b1;
    expireHit = candValid && (cntInc >= target);
  end

  // candidate counter, jitter offset and LFSR
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      jitQ  <= '0;
      lfsrQ <= LFSR_SEED;
    end else if (strb.advance) begin
      cntQ  <= '0;
      jitQ  <= jitterEn ? lfsrQ[JIT_W-1:0] : '0;
      lfsrQ <= lfsr16Next(lfsrQ);
    end else if (candValid) begin
      cntQ  <= cntInc;
    end
  end

  // sample start pulse and tag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ <= 1'b0;
      tagQ   <= '0;
    end else begin
      startQ <= strb.launch;
      if (strb.launch) tagQ <= candTag;
    end
  end

  // collision counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  collQ <= '0;
    else if (collClr)                           collQ <= '0;
    else if (strb.collide && collQ != COLL_MAX) collQ <= collQ + 1'b1;
  end

  assign sampleStart = startQ;
  assign sampleTag   = tagQ;
  assign collCount   = collQ;

  // R5: each dropped selection adds one below saturation
  a_r5_coll_inc: assert property (@(posedge clk) disable iff (!rstN)
    strb.collide && !collClr && collQ != COLL_MAX |=> collQ == $past(collQ) + 1'b1);

  // R8: saturated count stays put unless cleared
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rstN)
    collQ == COLL_MAX && !collClr |=> collQ == COLL_MAX);

  // R9: clear wins over everything
  a_r9_clear: assert property (@(posedge clk) disable iff (!rstN)
    collClr |=> collQ == '0);

  // R6: a selection point always restarts the window
  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> cntQ == '0);

endmodule

// File: rtl/op_sample_sel.sv
module op_sample_sel
  import opsamp_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int TAG_W        = 8,
  parameter int COLL_W       = 32,
  parameter int MIN_INTERVAL = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              candValid,
  input  logic [TAG_W-1:0]  candTag,
  input  logic [CNT_W-1:0]  interval,
  input  logic              jitterEn,
  input  logic              doneValid,
  input  logic              collClr,
  output logic              sampleStart,
  output logic [TAG_W-1:0]  sampleTag,
  output logic              busy,
  output logic [COLL_W-1:0] collCount
);

  localparam int JIT_W = 8;

  samp_strobe_t strb;
  logic         expireHit;

  opsamp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .expireHit (expireHit),
    .doneValid (doneValid),
    .strb      (strb),
    .busy      (busy)
  );

  opsamp_dp #(
    .CNT_W        (CNT_W),
    .TAG_W        (TAG_W),
    .COLL_W       (COLL_W),
    .JIT_W        (JIT_W),
    .MIN_INTERVAL (MIN_INTERVAL)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .candValid   (candValid),
    .candTag     (candTag),
    .interval    (interval),
    .jitterEn    (jitterEn),
    .collClr     (collClr),
    .strb        (strb),
    .expireHit   (expireHit),
    .sampleStart (sampleStart),
    .sampleTag   (sampleTag),
    .collCount   (collCount)
  );

  // R5: a start only follows a cycle with the slot free
  a_r5_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    sampleStart |-> !$past(busy));

  // R4: busy is raised together with the start pulse
  a_r4_busy_with_start: assert property (@(posedge clk) disable iff (!rstN)
    sampleStart |-> busy);

endmodule

// File: tb/op_sample_sel_test.sv
module op_sample_sel_test;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int TAG_W  = 8;
  localparam int COLL_W = 4;
  localparam int MINIV  = 16;
  localparam logic [COLL_W-1:0] CMAX = '1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              candValid = 1'b0;
  logic [TAG_W-1:0]  candTag = '0;
  logic [CNT_W-1:0]  interval = '0;
  logic              jitterEn = 1'b0;
  logic              doneValid = 1'b0;
  logic              collClr = 1'b0;
  logic              sampleStart;
  logic [TAG_W-1:0]  sampleTag;
  logic              busy;
  logic [COLL_W-1:0] collCount;

  int errors = 0;
  int checks = 0;
  int startsSeen = 0;
  int collSeen = 0;
  bit finished = 1'b0;

  // reference model state
  int        mCnt, mJit;
  logic [15:0] mLfsr;
  bit        mBusy, eStart;
  logic [TAG_W-1:0]  eTag;
  logic [COLL_W-1:0] eColl;

  // knobs
  int pCand, pDone, pClr;
  string phase;

  op_sample_sel #(.CNT_W(CNT_W), .TAG_W(TAG_W), .COLL_W(COLL_W), .MIN_INTERVAL(MINIV)) uut (
    .clk(clk), .rstN(rstN), .candValid(candValid), .candTag(candTag),
    .interval(interval), .jitterEn(jitterEn), .doneValid(doneValid),
    .collClr(collClr), .sampleStart(sampleStart), .sampleTag(sampleTag),
    .busy(busy), .collCount(collCount)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] stepLfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic int baseOf(input logic [CNT_W-1:0] iv);
    return (iv == 0) ? MINIV : int'(iv);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance the model by one clock edge using the inputs now driven
  task automatic modelStep();
    bit expire, launch, collide;
    expire = candValid && (mCnt + 1 >= baseOf(interval) + mJit);
    launch = expire && !mBusy;
    collide = expire && mBusy;
    eStart = launch;
    if (launch) eTag = candTag;
    if (expire) begin
      mCnt = 0;
      mJit = jitterEn ? int'(mLfsr[7:0]) : 0;
      mLfsr = stepLfsr(mLfsr);
    end else if (candValid) mCnt++;
    if (launch) mBusy = 1'b1;
    else if (doneValid) mBusy = 1'b0;
    if (collClr) eColl = '0;
    else if (collide && eColl != CMAX) eColl = eColl + 1'b1;
    if (launch) startsSeen++;
    if (collide) collSeen++;
  endtask

  task automatic compareAll();
    check(phase, "sampleStart", int'(sampleStart), int'(eStart));
    check(phase, "busy", int'(busy), int'(mBusy));
    check(phase, "collCount", int'(collCount), int'(eColl));
    if (eStart) check(phase, "sampleTag", int'(sampleTag), int'(eTag));
  endtask

  task automatic runPhase(input string name, input int cycles);
    phase = name;
    for (int i = 0; i < cycles; i++) begin
      candValid = ($urandom % 100) < pCand;
      candTag   = TAG_W'($urandom);
      doneValid = ($urandom % 100) < pDone;
      collClr   = ($urandom % 1000) < pClr;
      modelStep();
      @(negedge clk);
      compareAll();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    mCnt = 0; mJit = 0; mLfsr = 16'hACE1; mBusy = 0; eStart = 0; eTag = '0; eColl = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    phase = "R4 reset";
    compareAll();

    // R1 directed: interval 3, a gap in candidates, start lands after third valid
    interval = 3; phase = "R1 directed";
    candValid = 1; candTag = 8'h11; doneValid = 0; modelStep(); @(negedge clk); compareAll();
    candValid = 0;                     modelStep(); @(negedge clk); compareAll();
    candValid = 1; candTag = 8'h22;    modelStep(); @(negedge clk); compareAll();
    candValid = 1; candTag = 8'h5A;    modelStep(); @(negedge clk); compareAll();
    check("R1", "start after third candidate", int'(sampleStart), 1);
    check("R4", "tag of third candidate", int'(sampleTag), 8'h5A);

    // R10: completion pulses while idle do nothing
    candValid = 0; doneValid = 1; modelStep(); @(negedge clk); compareAll();
    check("R10", "busy after release", int'(busy), 0);
    doneValid = 1; modelStep(); @(negedge clk); compareAll();
    doneValid = 0;
    pCand = 60; pDone = 30; pClr = 0;
    interval = 0; phase = "R10 idle done"; pDone = 80; runPhase("R10 idle done", 400);

    // R1 random: several intervals, frequent completion
    pDone = 40;
    interval = 5; runPhase("R1 ivl5", 2000);
    interval = 1; runPhase("R1 ivl1", 1000);
    interval = 37; runPhase("R1 ivl37", 3000);

    // R2: zero selects the minimum interval
    interval = 0; runPhase("R2 min interval", 3000);

    // R3: jitter enabled across intervals
    jitterEn = 1;
    interval = 3; runPhase("R3 jitter ivl3", 6000);
    interval = 0; runPhase("R3 jitter min", 6000);
    jitterEn = 0;

    // R5 / R6 / R7: rare completion forces collisions; window keeps restarting
    interval = 2; pDone = 3; runPhase("R5 R6 R7 collisions", 3000);

    // R8: counter pinned at its maximum
    pDone = 1; runPhase("R8 saturate", 2000);
    check("R8", "saturated count", int'(collCount), int'(CMAX));

    // R9: clear pulses mixed with collisions
    pClr = 40; pDone = 5; runPhase("R9 clear", 4000);
    phase = "R9 directed"; collClr = 1; candValid = 0; doneValid = 0;
    modelStep(); @(negedge clk); compareAll();
    check("R9", "count after clear", int'(collCount), 0);
    collClr = 0; pClr = 0;

    // mixed random with jitter toggling
    pDone = 20; interval = 4;
    for (int k = 0; k < 8; k++) begin
      jitterEn = k[0];
      runPhase("R1 R3 R5 mixed", 1500);
    end

    check("R4", "starts observed", int'(startsSeen > 100), 1);
    check("R5", "collisions observed", int'(collSeen > 100), 1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule